// File: doc/BRIEF.md
# Pin pull control latch sequencer

This block sets the pull resistors on a row of general-purpose pins. Software does not write a pin's pull setting directly. It first writes a shared 2-bit mode register with the pull it wants. After waiting, it raises the clock bits of the pins that should take that mode. It then waits again and clears those bits. Each pin holds its own latched pull state. That state goes to the pad as a pull-up enable and a pull-down enable.

A pin loads the shared mode only when its clock bit is cleared. The load is kept only if the timing rules were met: the mode was stable long enough before the clock bit rose, it did not change while the bit was high, and the bit stayed high long enough. A load that breaks these rules leaves the pin as it was and sets a sticky error flag. The latched states cannot be read over the bus. Reads return only the mode register and the clock registers.

Top module: `pull_latch_seq`

## Requirements
- R1: After reset, every pull_up and pull_dn bit is 0, pull_err is 0, and the mode register and every clock register read 0.
- R2: A write to address 0x94 stores bits [1:0] of the write data as the mode. A read of 0x94 returns that mode in bits [1:0], with every other bit 0.
- R3: The clock register for bank b is at 0x98 + 4*b. Pin p is bit p mod 32 of bank p/32. A read returns the last written value, with bits above the last pin forced to 0 (0x003FFFFF in bank 1 for 54 pins).
- R4: A pin captures the mode when its clock bit goes from 1 to 0, provided the timing rules hold. Mode 1 gives pull_dn=1 and pull_up=0. Mode 2 gives pull_up=1 and pull_dn=0. Mode 0 gives both 0. The outputs change on the clock edge of that register write.
- R5: Mode value 3 is captured as no pull: pull_up=0 and pull_dn=0.
- R6: If a pin's clock bit rises fewer than SETUP (150) cycles after the mode last changed value, the pin's later capture is ignored and pull_err is set.
- R7: A capture is ignored and pull_err is set if the clock bit is cleared fewer than HOLD (150) cycles after the latest write to that bank's clock register that raised any bit.
- R8: If the mode changes value while a pin's clock bit is high, that pin's capture is ignored and pull_err is set.
- R9: A pin whose clock bit does not fall keeps its latched pull. This holds whether the bit stays 0, stays 1 or rises. It holds even when other pins in the same write capture.
- R10: pull_err stays 1 until reset, including across later valid captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte address for writes and reads |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| pull_up | output | NUM_PINS (54) | Per-pin pull-up enable |
| pull_dn | output | NUM_PINS (54) | Per-pin pull-down enable |
| pull_err | output | 1 | Sticky flag for a capture that broke the timing rules |

## Verification
The assertions check, on every cycle, that a latched pull changes only on an edge where its bank's clock register has a bit falling. They also check that the mode and clock registers hold exactly what was last written, that a mode change restarts the setup count, and that the error flag never drops and only rises after a bus write. Which mode value ends up on which pin's pull_up and pull_dn can only be shown by the bench scenarios. The same holds for how mode 3 is decoded, and for whether each of the three timing violations is caught while a correctly timed sequence is accepted. Each of those needs a full write sequence and a comparison with an independently tracked pin map.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2
    } pull_t;

    // The reserved code 3 falls back to no pull.
    function automatic pull_t decode_mode(input logic [1:0] raw);
        case (raw)
            2'd1:    return PULL_DOWN;
            2'd2:    return PULL_UP;
            default: return PULL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pull_mode_reg.sv
module pull_mode_reg
    import pull_seq_pkg::*;
#(
    parameter int SETUP = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output logic [1:0] mode_raw,
    output pull_t      mode_dec,
    output logic       mode_ok,
    output logic       mode_chg
);

    localparam int AGE_W = $clog2(SETUP + 1);

    typedef struct packed {
        logic [1:0]       mode;
        logic [AGE_W-1:0] age;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        mode_chg = wr_en && (wr_val != st_q.mode);
        if (mode_chg) begin
            st_d.mode = wr_val;
            st_d.age  = '0;
        end else if (st_q.age < AGE_W'(SETUP)) begin
            st_d.age = st_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_raw = st_q.mode;
    assign mode_dec = decode_mode(st_q.mode);
    assign mode_ok  = (st_q.age >= AGE_W'(SETUP));

    // R6: a change of mode restarts the setup window
    p_chg_restarts_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !mode_ok);

    // R2: the mode register holds the low two bits last written
    p_mode_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_raw == $past(wr_val)));

endmodule

// File: rtl/pull_bank.sv
module pull_bank
    import pull_seq_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int HOLD   = 150,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_val,
    input  logic              mode_chg,
    input  logic              mode_ok,
    input  pull_t             mode,
    output logic [DATA_W-1:0] rd_word,
    output logic [WIDTH-1:0]  pull_up,
    output logic [WIDTH-1:0]  pull_dn,
    output logic              reject
);

    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [WIDTH-1:0]      clk_en;
        logic [WIDTH-1:0]      armed;
        logic [HW-1:0]         hold;
        logic [WIDTH-1:0][1:0] latch;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic [WIDTH-1:0] rise, fall;
    logic             hold_ok;

    always_comb begin
        st_d    = st_q;
        reject  = 1'b0;
        rise    = wr_en ? (wr_val & ~st_q.clk_en) : '0;
        fall    = wr_en ? (st_q.clk_en & ~wr_val) : '0;
        hold_ok = (st_q.hold >= HW'(HOLD));

        if (wr_en) begin
            st_d.clk_en = wr_val;
        end

        // Hold window restarts on any write that raises a bit of this bank
        if (|rise) begin
            st_d.hold = '0;
        end else if (st_q.hold < HW'(HOLD)) begin
            st_d.hold = st_q.hold + 1'b1;
        end

        // A pin is armed when it rises after a settled mode and stays armed
        // until it falls or the mode moves under it
        if (mode_chg) begin
            st_d.armed = '0;
        end
        st_d.armed = (st_d.armed | (rise & {WIDTH{mode_ok}})) & ~fall;

        for (int i = 0; i < WIDTH; i++) begin
            if (fall[i]) begin
                if (st_q.armed[i] && hold_ok) begin
                    st_d.latch[i] = mode;
                end else begin
                    reject = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word = DATA_W'(st_q.clk_en);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        assign pull_up[g] = (st_q.latch[g] == PULL_UP);
        assign pull_dn[g] = (st_q.latch[g] == PULL_DOWN);
    end

    // R9: latched pulls move only on an edge where some clock bit falls
    p_latch_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && |(rd_word[WIDTH-1:0] & ~wr_val)) |=> $stable(st_q.latch));

    // R3: the clock register holds what was last written
    p_clk_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_word[WIDTH-1:0] == $past(wr_val)));

endmodule

// File: rtl/pull_latch_seq.sv
module pull_latch_seq
    import pull_seq_pkg::*;
#(
    parameter int          NUM_PINS  = 54,
    parameter int          SETUP     = 150,
    parameter int          HOLD      = 150,
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int unsigned MODE_ADDR = 'h94,
    parameter int unsigned CLK_BASE  = 'h98
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pull_up,
    output logic [NUM_PINS-1:0] pull_dn,
    output logic                pull_err
);

    localparam int BANK_W    = DATA_W;
    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t               st_d, st_q;
    logic                  mode_wr;
    logic [1:0]            mode_raw;
    pull_t                 mode_dec;
    logic                  mode_ok;
    logic                  mode_chg;
    logic [DATA_W-1:0]     bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_rej;

    assign mode_wr = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));

    pull_mode_reg #(
        .SETUP (SETUP)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr),
        .wr_val   (bus_wdata[1:0]),
        .mode_raw (mode_raw),
        .mode_dec (mode_dec),
        .mode_ok  (mode_ok),
        .mode_chg (mode_chg)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = ((NUM_PINS - b * BANK_W) > BANK_W) ? BANK_W
                                                              : (NUM_PINS - b * BANK_W);
        logic bank_wr;
        assign bank_wr = bus_wr && (bus_addr == ADDR_W'(CLK_BASE + 4 * b));

        pull_bank #(
            .WIDTH  (BW),
            .HOLD   (HOLD),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .wr_val   (bus_wdata[BW-1:0]),
            .mode_chg (mode_chg),
            .mode_ok  (mode_ok),
            .mode     (mode_dec),
            .rd_word  (bank_rd[b]),
            .pull_up  (pull_up[b*BANK_W +: BW]),
            .pull_dn  (pull_dn[b*BANK_W +: BW]),
            .reject   (bank_rej[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(MODE_ADDR)) begin
            bus_rdata[1:0] = mode_raw;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(CLK_BASE + 4 * b)) begin
                bus_rdata = bank_rd[b];
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = st_q.err | (|bank_rej);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_err = st_q.err;

    // R10: the error flag never drops outside reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pull_err |=> pull_err);

    // R6: the error flag rises only after a bus write
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_err) |-> $past(bus_wr));

endmodule

// File: tb/pull_latch_seq_tb.sv
`timescale 1ns/1ps
module pull_latch_seq_tb;

    localparam int NP   = 54;
    localparam int WAIT = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pull_up, pull_dn;
    logic          pull_err;

    always #2 clk = ~clk;

    pull_latch_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pull_up   (pull_up),
        .pull_dn   (pull_dn),
        .pull_err  (pull_err)
    );

    typedef struct {
        string         tag;
        bit            is_rd;
        logic [31:0]   rd;
        logic [NP-1:0] up;
        logic [NP-1:0] dn;
        logic          err;
    } item_t;

    item_t         sb [$];
    int            checks = 0;
    int            fails  = 0;
    logic [NP-1:0] e_up = '0;
    logic [NP-1:0] e_dn = '0;
    logic          e_err = 1'b0;

    // Monitor: compare queued expectations away from the active edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (it.is_rd) begin
                    if (bus_rdata !== it.rd) begin
                        fails++;
                        $display("FAIL %s: rdata actual=%h expected=%h", it.tag, bus_rdata, it.rd);
                    end
                end else if (pull_up !== it.up || pull_dn !== it.dn || pull_err !== it.err) begin
                    fails++;
                    $display("FAIL %s: actual up=%h dn=%h err=%b expected up=%h dn=%h err=%b",
                             it.tag, pull_up, pull_dn, pull_err, it.up, it.dn, it.err);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk_out(input string tag);
        item_t it;
        it.tag = tag; it.is_rd = 1'b0; it.rd = '0;
        it.up = e_up; it.dn = e_dn; it.err = e_err;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic exp_rd(input string tag, input logic [7:0] a, input logic [31:0] v);
        item_t it;
        bus_addr = a;
        it.tag = tag; it.is_rd = 1'b1; it.rd = v;
        it.up = '0; it.dn = '0; it.err = 1'b0;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    // Model of a correctly timed capture: mode 1 down, 2 up, 0 and 3 none
    task automatic model_capture(input logic [NP-1:0] mask, input logic [1:0] m);
        for (int i = 0; i < NP; i++) begin
            if (mask[i]) begin
                e_up[i] = (m == 2'd2);
                e_dn[i] = (m == 2'd1);
            end
        end
    endtask

    task automatic capture(input logic [7:0] a, input logic [31:0] bits, input logic [1:0] m);
        wr(8'h94, {30'd0, m});
        idle(WAIT);
        wr(a, bits);
        idle(WAIT);
        wr(a, 32'd0);
    endtask

    task automatic do_reset;
        @(posedge clk); #1;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        e_up = '0; e_dn = '0; e_err = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        chk_out("R1 outputs after reset");
        exp_rd("R1 mode register after reset", 8'h94, 32'd0);
        exp_rd("R1 bank1 clock register after reset", 8'h9C, 32'd0);

        wr(8'h94, 32'hFFFF_FFF9);
        exp_rd("R2 mode keeps only low bits", 8'h94, 32'd1);

        idle(WAIT);
        wr(8'h98, 32'h0000_0021);
        exp_rd("R3 bank0 clock readback", 8'h98, 32'h0000_0021);
        wr(8'h9C, 32'hFFFF_FFFF);
        exp_rd("R3 bank1 clock readback masked", 8'h9C, 32'h003F_FFFF);
        chk_out("R9 raising clock bits leaves pulls unchanged");

        idle(WAIT);
        wr(8'h98, 32'h0000_0001);
        model_capture(NP'(1) << 5, 2'd1);
        chk_out("R4 pin5 pull-down while pin0 still high R9");

        wr(8'h9C, 32'd0);
        model_capture({22'h3F_FFFF, 32'd0}, 2'd1);
        chk_out("R4 whole bank1 pull-down");

        wr(8'h98, 32'd0);
        model_capture(NP'(1), 2'd1);
        chk_out("R4 pin0 pull-down");

        capture(8'h98, 32'h0000_0020, 2'd2);
        model_capture(NP'(1) << 5, 2'd2);
        chk_out("R4 pin5 pull-up overwrite");

        capture(8'h9C, 32'h0000_0100, 2'd3);
        model_capture(NP'(1) << 40, 2'd3);
        chk_out("R5 mode 3 gives no pull on pin40");

        capture(8'h9C, 32'h0000_0002, 2'd0);
        model_capture(NP'(1) << 33, 2'd0);
        chk_out("R4 mode 0 clears pin33");

        wr(8'h94, 32'd2);
        idle(10);
        wr(8'h98, 32'h0000_0080);
        idle(WAIT);
        wr(8'h98, 32'd0);
        e_err = 1'b1;
        chk_out("R6 setup violation ignored on pin7");
        idle(50);
        chk_out("R10 error flag still set");

        do_reset;
        chk_out("R1 reset clears latched pulls and error");

        wr(8'h94, 32'd2);
        idle(WAIT);
        wr(8'h98, 32'h0000_0008);
        idle(20);
        wr(8'h98, 32'd0);
        e_err = 1'b1;
        chk_out("R7 hold violation ignored on pin3");

        do_reset;
        wr(8'h94, 32'd1);
        idle(WAIT);
        wr(8'h98, 32'h0000_0010);
        idle(50);
        wr(8'h94, 32'd2);
        idle(WAIT);
        wr(8'h98, 32'd0);
        e_err = 1'b1;
        chk_out("R8 mode change while high ignored on pin4");

        capture(8'h98, 32'h0000_0040, 2'd2);
        model_capture(NP'(1) << 6, 2'd2);
        chk_out("R10 error stays set across a valid capture");

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule